// File: doc/BRIEF.md
# Memory Region Attribute Lookup

This block decides, for each memory access, which memory type applies and whether the access must be refused. The requester presents a 32-bit address, what kind of access it is (instruction fetch, data read or data write) and whether the code is privileged. One clock later the block returns one of three memory types (normal, device or strongly-ordered), a permission-fault flag and a background-fault flag.

Software describes up to twelve address windows through a single write port. Each window has a base, a power-of-two size, an enable, eight subregion-disable bits, an access-permission code, an execute-never bit and a memory type. Windows may overlap. The highest-numbered window that matches decides the result, so a small no-access guard window can sit inside a larger RAM window. A subregion-disable bit removes one eighth of a window, so one descriptor can cover two separate spans.

When protection is switched off, a fixed default map applies and no access faults. In that map every address from 0xFC000000 upward is strongly-ordered and every lower address is normal.

Top module: `mpu_attr_lookup`

## Requirements
- R1: A request sampled with `req_valid` high at a rising edge raises `rsp_valid` and presents its result after that edge. `rsp_valid` is low after any edge at which `req_valid` was low.
- R2: There are twelve descriptors, indexed 0 to 11. When several enabled descriptors match an address, the result comes from the highest index among them.
- R3: Size code n is log2 of the window size in bytes. Codes below 5 are stored as 5 and codes above 32 as 32. A window matches when address bits [31:n] equal base bits [31:n]. Base bits below n are ignored.
- R4: A window is split into eight equal parts, numbered by address bits [n-1:n-3]. When disable bit i is set, part i does not match, and a lower-numbered window that covers the address decides the result.
- R5: With protection on, an access that matches no enabled window gives `rsp_bg_fault`=1 and `rsp_perm_fault`=0, with the type taken from the default map of R8.
- R6: Permission codes are: 0 no access; 1 read and write for privileged code only; 2 privileged read and write, unprivileged read only; 3 read and write for all; 5 privileged read only; 6 read only for all. Codes 4 and 7 act as no access. A read without read right faults. A write without write right faults.
- R7: An instruction fetch faults when the winning window has execute-never set, has a type other than normal, or denies a read to the requester.
- R8: With `mpu_on` low, no access faults. The type is strongly-ordered (2) for addresses at or above 0xFC000000 and normal (0) below.
- R9: Type codes are 0 normal, 1 device and 2 strongly-ordered. A stored type code of 3 reads back as strongly-ordered. Access-kind codes are 0 fetch, 1 read and 2 write. Kind 3 is handled as a read.
- R10: With `cfg_we` high, the descriptor fields are written into slot `cfg_idx`. Lookups see the new values from the next cycle on. A write with an index of 12 or above changes nothing.
- R11: Reset (synchronous, active high) disables all twelve descriptors and clears `rsp_valid` and the result outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mpu_on | input | 1 | Protection enable; low selects the default map |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_idx | input | 4 | Descriptor slot to write |
| cfg_base | input | 32 | Window base address |
| cfg_size | input | 6 | Window size as log2 bytes |
| cfg_en | input | 1 | Window enable |
| cfg_srd | input | 8 | Subregion-disable bits |
| cfg_ap | input | 3 | Access-permission code |
| cfg_xn | input | 1 | Execute-never |
| cfg_type | input | 2 | Memory type code |
| req_valid | input | 1 | Lookup request valid |
| req_addr | input | 32 | Access address |
| req_kind | input | 2 | Access kind code |
| req_priv | input | 1 | Access is privileged |
| rsp_valid | output | 1 | Result valid |
| rsp_type | output | 2 | Resolved memory type |
| rsp_perm_fault | output | 1 | Permission fault |
| rsp_bg_fault | output | 1 | No enabled window matched |

## Verification
The assertions assume that the access kind presented with a request is never the reserved code 3. The bench keeps to this except in one directed case, which checks the read fallback at the ports. The assertions also assume that `mpu_on` is steady over each request cycle, which holds because the bench changes it only between lookups. Every lookup is driven on a falling edge and held for exactly one cycle. Descriptor writes and requests are never issued in the same cycle, so each lookup sees a settled descriptor set.

// File: rtl/mpu_pkg.sv
package mpu_pkg;

    localparam int ADDR_W     = 32;
    localparam int SUBREGIONS = 8;
    localparam int SRD_W      = SUBREGIONS;
    localparam int SUB_BITS   = $clog2(SUBREGIONS);
    localparam int SIZE_W     = 6;
    localparam int SIZE_MIN   = 5;
    localparam int SIZE_MAX   = ADDR_W;

    localparam logic [ADDR_W-1:0] PERIPH_START = 32'hFC00_0000;

    typedef enum logic [1:0] {
        MT_NORMAL = 2'd0,
        MT_DEVICE = 2'd1,
        MT_STRONG = 2'd2
    } mem_type_e;

    typedef enum logic [1:0] {
        AK_FETCH = 2'd0,
        AK_READ  = 2'd1,
        AK_WRITE = 2'd2,
        AK_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [2:0] {
        AP_NONE    = 3'd0,
        AP_PRW     = 3'd1,
        AP_PRW_URO = 3'd2,
        AP_FULL    = 3'd3,
        AP_RSV4    = 3'd4,
        AP_PRO     = 3'd5,
        AP_ALLRO   = 3'd6,
        AP_RSV7    = 3'd7
    } perm_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [SIZE_W-1:0] size;
        logic              en;
        logic [SRD_W-1:0]  srd;
        perm_e             ap;
        logic              xn;
        mem_type_e         mtype;
    } region_t;

    // Keep the size code inside the legal window
    function automatic logic [SIZE_W-1:0] clamp_size(input logic [SIZE_W-1:0] s);
        if (s < SIZE_W'(SIZE_MIN))      return SIZE_W'(SIZE_MIN);
        else if (s > SIZE_W'(SIZE_MAX)) return SIZE_W'(SIZE_MAX);
        else                            return s;
    endfunction

    // The spare type code folds onto strongly-ordered
    function automatic mem_type_e fix_type(input logic [1:0] t);
        if (t == 2'd3) return MT_STRONG;
        else           return mem_type_e'(t);
    endfunction

    function automatic logic can_read(input perm_e ap, input logic priv);
        case (ap)
            AP_PRW, AP_PRO:                 return priv;
            AP_PRW_URO, AP_FULL, AP_ALLRO:  return 1'b1;
            default:                        return 1'b0;
        endcase
    endfunction

    function automatic logic can_write(input perm_e ap, input logic priv);
        case (ap)
            AP_PRW, AP_PRW_URO: return priv;
            AP_FULL:            return 1'b1;
            default:            return 1'b0;
        endcase
    endfunction

    // Fixed map used when protection is off or nothing matches
    function automatic mem_type_e default_type(input logic [ADDR_W-1:0] a);
        if (a >= PERIPH_START) return MT_STRONG;
        else                   return MT_NORMAL;
    endfunction

endpackage

// File: rtl/mpu_region_file.sv
module mpu_region_file
    import mpu_pkg::*;
#(
    parameter int NUM_REGIONS = 12,
    localparam int IDX_W = $clog2(NUM_REGIONS)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  region_t                     wr_desc,
    output region_t [NUM_REGIONS-1:0]   regions
);

    region_t [NUM_REGIONS-1:0] slot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGIONS; i++) begin
                slot_q[i] <= '0;
            end
        end else if (wr_en) begin
            for (int i = 0; i < NUM_REGIONS; i++) begin
                if (32'(wr_idx) == i) begin
                    slot_q[i].base  <= wr_desc.base;
                    slot_q[i].size  <= clamp_size(wr_desc.size);
                    slot_q[i].en    <= wr_desc.en;
                    slot_q[i].srd   <= wr_desc.srd;
                    slot_q[i].ap    <= wr_desc.ap;
                    slot_q[i].xn    <= wr_desc.xn;
                    slot_q[i].mtype <= wr_desc.mtype;
                end
            end
        end
    end

    assign regions = slot_q;

endmodule

// File: rtl/mpu_region_match.sv
module mpu_region_match
    import mpu_pkg::*;
(
    input  logic [ADDR_W-1:0] base,
    input  logic [SIZE_W-1:0] size,
    input  logic              en,
    input  logic [SRD_W-1:0]  srd,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);

    logic [ADDR_W-1:0]   keep_mask;
    logic [SUB_BITS-1:0] sub_idx;
    logic                span_hit;

    always_comb begin
        if (size >= SIZE_W'(ADDR_W)) keep_mask = '0;
        else                         keep_mask = {ADDR_W{1'b1}} << size;
        // The subregion number sits just under the compared bits
        sub_idx  = SUB_BITS'(addr >> (size - SIZE_W'(SUB_BITS)));
        span_hit = ((addr ^ base) & keep_mask) == '0;
        hit      = en && span_hit && !srd[sub_idx];
    end

endmodule

// File: rtl/mpu_winner_pick.sv
module mpu_winner_pick #(
    parameter int NUM_REGIONS = 12,
    localparam int IDX_W = $clog2(NUM_REGIONS)
) (
    input  logic [NUM_REGIONS-1:0] hits,
    output logic                   any_hit,
    output logic [IDX_W-1:0]       win_idx
);

    // Ascending scan: a later (higher) hit overrides an earlier one
    always_comb begin
        any_hit = 1'b0;
        win_idx = '0;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (hits[i]) begin
                any_hit = 1'b1;
                win_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/mpu_attr_lookup.sv
module mpu_attr_lookup
    import mpu_pkg::*;
#(
    parameter int NUM_REGIONS = 12,
    localparam int IDX_W = $clog2(NUM_REGIONS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 mpu_on,
    input  logic                 cfg_we,
    input  logic [IDX_W-1:0]     cfg_idx,
    input  logic [ADDR_W-1:0]    cfg_base,
    input  logic [SIZE_W-1:0]    cfg_size,
    input  logic                 cfg_en,
    input  logic [SRD_W-1:0]     cfg_srd,
    input  logic [2:0]           cfg_ap,
    input  logic                 cfg_xn,
    input  logic [1:0]           cfg_type,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [1:0]           req_kind,
    input  logic                 req_priv,
    output logic                 rsp_valid,
    output logic [1:0]           rsp_type,
    output logic                 rsp_perm_fault,
    output logic                 rsp_bg_fault
);

    region_t                    wr_desc;
    region_t [NUM_REGIONS-1:0]  regions;
    logic    [NUM_REGIONS-1:0]  hits;
    logic                       any_hit;
    logic    [IDX_W-1:0]        win_idx;
    region_t                    win;
    acc_kind_e                  kind;

    mem_type_e nxt_type, type_q;
    logic      nxt_pf, nxt_bg;

    always_comb begin
        wr_desc.base  = cfg_base;
        wr_desc.size  = cfg_size;
        wr_desc.en    = cfg_en;
        wr_desc.srd   = cfg_srd;
        wr_desc.ap    = perm_e'(cfg_ap);
        wr_desc.xn    = cfg_xn;
        wr_desc.mtype = fix_type(cfg_type);
    end

    mpu_region_file #(.NUM_REGIONS(NUM_REGIONS)) u_file (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we),
        .wr_idx  (cfg_idx),
        .wr_desc (wr_desc),
        .regions (regions)
    );

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_match
        mpu_region_match u_match (
            .base (regions[g].base),
            .size (regions[g].size),
            .en   (regions[g].en),
            .srd  (regions[g].srd),
            .addr (req_addr),
            .hit  (hits[g])
        );
    end

    mpu_winner_pick #(.NUM_REGIONS(NUM_REGIONS)) u_pick (
        .hits    (hits),
        .any_hit (any_hit),
        .win_idx (win_idx)
    );

    assign win  = regions[win_idx];
    assign kind = acc_kind_e'(req_kind);

    always_comb begin
        nxt_type = default_type(req_addr);
        nxt_pf   = 1'b0;
        nxt_bg   = 1'b0;
        if (mpu_on) begin
            if (!any_hit) begin
                nxt_bg = 1'b1;
            end else begin
                nxt_type = win.mtype;
                case (kind)
                    AK_FETCH: nxt_pf = win.xn || (win.mtype != MT_NORMAL)
                                       || !can_read(win.ap, req_priv);
                    AK_WRITE: nxt_pf = !can_write(win.ap, req_priv);
                    default:  nxt_pf = !can_read(win.ap, req_priv);
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid      <= 1'b0;
            type_q         <= MT_NORMAL;
            rsp_perm_fault <= 1'b0;
            rsp_bg_fault   <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                type_q         <= nxt_type;
                rsp_perm_fault <= nxt_pf;
                rsp_bg_fault   <= nxt_bg;
            end
        end
    end

    assign rsp_type = type_q;

endmodule

// File: rtl/mpu_attr_lookup_chk.sv
module mpu_attr_lookup_chk (
    input logic        clk,
    input logic        rst,
    input logic        mpu_on,
    input logic        req_valid,
    input logic [31:0] req_addr,
    input logic [1:0]  req_kind,
    input logic        rsp_valid,
    input logic [1:0]  rsp_type,
    input logic        rsp_perm_fault,
    input logic        rsp_bg_fault
);

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (rsp_valid == $past(req_valid)));

    // R11
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rsp_valid && !rsp_perm_fault && !rsp_bg_fault && rsp_type == 2'd0));

    // R5
    fault_excl_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !(rsp_bg_fault && rsp_perm_fault));

    // R8
    off_nofault_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !mpu_on) |=> (!rsp_perm_fault && !rsp_bg_fault));

    // R8
    off_strong_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !mpu_on && req_addr[31:26] == 6'h3F) |=> (rsp_type == 2'd2));

    // R7
    fetch_type_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && mpu_on && req_kind == 2'd0) |=>
            (rsp_bg_fault || rsp_type == 2'd0 || rsp_perm_fault));

    // R9
    type_code_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_type != 2'd3));

endmodule

bind mpu_attr_lookup mpu_attr_lookup_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .mpu_on         (mpu_on),
    .req_valid      (req_valid),
    .req_addr       (req_addr),
    .req_kind       (req_kind),
    .rsp_valid      (rsp_valid),
    .rsp_type       (rsp_type),
    .rsp_perm_fault (rsp_perm_fault),
    .rsp_bg_fault   (rsp_bg_fault)
);

// File: tb/tb_mpu_attr_lookup.sv
`timescale 1ns/1ps
module tb_mpu_attr_lookup;

    localparam int NR = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mpu_on = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [31:0] cfg_base = '0;
    logic [5:0]  cfg_size = '0;
    logic        cfg_en = 1'b0;
    logic [7:0]  cfg_srd = '0;
    logic [2:0]  cfg_ap = '0;
    logic        cfg_xn = 1'b0;
    logic [1:0]  cfg_type = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_kind = '0;
    logic        req_priv = 1'b0;
    logic        rsp_valid;
    logic [1:0]  rsp_type;
    logic        rsp_perm_fault;
    logic        rsp_bg_fault;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] m_base [NR];
    int          m_size [NR];
    bit          m_en   [NR];
    logic [7:0]  m_srd  [NR];
    int          m_ap   [NR];
    bit          m_xn   [NR];
    int          m_type [NR];

    always #4 clk = ~clk;

    mpu_attr_lookup dut (
        .clk(clk), .rst(rst), .mpu_on(mpu_on),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base), .cfg_size(cfg_size),
        .cfg_en(cfg_en), .cfg_srd(cfg_srd), .cfg_ap(cfg_ap), .cfg_xn(cfg_xn),
        .cfg_type(cfg_type),
        .req_valid(req_valid), .req_addr(req_addr), .req_kind(req_kind),
        .req_priv(req_priv),
        .rsp_valid(rsp_valid), .rsp_type(rsp_type),
        .rsp_perm_fault(rsp_perm_fault), .rsp_bg_fault(rsp_bg_fault)
    );

    function automatic bit rd_ok(int ap, bit priv);
        case (ap)
            1, 5:    return priv;
            2, 3, 6: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit wr_ok(int ap, bit priv);
        case (ap)
            1, 2:    return priv;
            3:       return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // Expected result derived from the written requirements
    function automatic void expect_of(input logic [31:0] a, input int kind, input bit priv,
                                      input bit on, output int et, output bit epf, output bit ebg);
        int win;
        win = -1;
        et  = (a >= 32'hFC00_0000) ? 2 : 0;
        epf = 0;
        ebg = 0;
        if (on) begin
            for (int r = 0; r < NR; r++) begin
                int s;
                logic [31:0] msk;
                int sub;
                s   = m_size[r];
                msk = (s >= 32) ? 32'h0 : (32'hFFFF_FFFF << s);
                sub = int'((a >> (s - 3)) & 32'd7);
                if (m_en[r] && (((a ^ m_base[r]) & msk) == 0) && !m_srd[r][sub]) win = r;
            end
            if (win < 0) begin
                ebg = 1;
            end else begin
                et = m_type[win];
                if (kind == 0)      epf = m_xn[win] || (et != 0) || !rd_ok(m_ap[win], priv);
                else if (kind == 2) epf = !wr_ok(m_ap[win], priv);
                else                epf = !rd_ok(m_ap[win], priv);
            end
        end
    endfunction

    // Called on a falling edge; returns on a falling edge
    task automatic cfg(input int idx, input logic [31:0] base, input int size, input bit en,
                       input logic [7:0] srd, input int ap, input bit xn, input int ty);
        cfg_we   = 1'b1;
        cfg_idx  = 4'(idx);
        cfg_base = base;
        cfg_size = 6'(size);
        cfg_en   = en;
        cfg_srd  = srd;
        cfg_ap   = 3'(ap);
        cfg_xn   = xn;
        cfg_type = 2'(ty);
        if (idx < NR) begin
            m_base[idx] = base;
            m_size[idx] = (size < 5) ? 5 : ((size > 32) ? 32 : size);
            m_en[idx]   = en;
            m_srd[idx]  = srd;
            m_ap[idx]   = ap;
            m_xn[idx]   = xn;
            m_type[idx] = (ty == 3) ? 2 : ty;
        end
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic look(input logic [31:0] a, input int kind, input bit priv, input string tag);
        int et;
        bit epf, ebg;
        expect_of(a, (kind == 3) ? 1 : kind, priv, mpu_on, et, epf, ebg);
        req_valid = 1'b1;
        req_addr  = a;
        req_kind  = 2'(kind);
        req_priv  = priv;
        @(negedge clk);
        req_valid = 1'b0;
        checks++;
        if (!rsp_valid || rsp_type != 2'(et) || rsp_perm_fault != epf || rsp_bg_fault != ebg) begin
            errors++;
            $display("FAIL %s addr=%h kind=%0d priv=%0d got v=%0b type=%0d pf=%0b bg=%0b exp v=1 type=%0d pf=%0b bg=%0b",
                     tag, a, kind, priv, rsp_valid, rsp_type, rsp_perm_fault, rsp_bg_fault, et, epf, ebg);
        end
    endtask

    task automatic check_bit(input bit got, input bit exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%0b exp=%0b", tag, got, exp);
        end
    endtask

    task automatic clear_model();
        for (int r = 0; r < NR; r++) begin
            m_base[r] = '0; m_size[r] = 5; m_en[r] = 0; m_srd[r] = '0;
            m_ap[r] = 0; m_xn[r] = 0; m_type[r] = 0;
        end
    endtask

    task automatic sweep_top(input string tag);
        for (int i = 0; i < 64; i++) begin
            for (int k = 0; k < 3; k++) begin
                for (int p = 0; p < 2; p++) begin
                    look((32'(i) << 26) | 32'h0000_1230, k, p[0], tag);
                end
            end
        end
    endtask

    task automatic program_map();
        cfg(0,  32'h0000_0000, 20, 1, 8'h00, 3, 0, 0);
        cfg(1,  32'hF000_0000, 23, 1, 8'h00, 5, 1, 0);
        cfg(2,  32'h0800_0000, 18, 1, 8'h00, 3, 0, 0);
        cfg(3,  32'h0840_0000, 18, 1, 8'h00, 2, 1, 0);
        cfg(4,  32'hFC00_0000, 26, 1, 8'b0000_1110, 3, 1, 1);
        cfg(5,  32'h0800_0020, 5,  1, 8'h00, 0, 1, 0);
        cfg(6,  32'h0800_0820, 5,  1, 8'h00, 0, 1, 0);
        cfg(7,  32'h3000_0000, 16, 0, 8'h00, 3, 0, 0);
        cfg(8,  32'h0800_1000, 12, 1, 8'h00, 6, 0, 0);
        cfg(9,  32'h2000_0000, 2,  1, 8'h00, 3, 0, 0);
        cfg(10, 32'h5000_0000, 12, 1, 8'h00, 3, 0, 3);
        cfg(11, 32'hFFF8_0000, 19, 1, 8'h00, 1, 1, 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        clear_model();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        // R11: reset state at the ports
        check_bit(rsp_valid, 1'b0, "R11 rsp_valid after reset");
        check_bit(rsp_perm_fault || rsp_bg_fault || (rsp_type != 0), 1'b0, "R11 outputs after reset");
        @(negedge clk);

        // R8: default map with protection off
        mpu_on = 1'b0;
        sweep_top("R8 default map");
        look(32'hFBFF_FFFC, 0, 0, "R8 just below peripheral space");
        look(32'hFC00_0000, 2, 0, "R8 start of peripheral space");

        // R11: reset left every slot disabled, so everything is a background fault (R5)
        mpu_on = 1'b1;
        sweep_top("R5 no windows");

        // R1: idle cycle after a lookup drops rsp_valid
        @(negedge clk);
        check_bit(rsp_valid, 1'b0, "R1 valid drops when idle");

        program_map();

        // R10: a write becomes visible on the very next cycle
        cfg(7, 32'h3000_0000, 16, 1, 8'h00, 3, 0, 1);
        look(32'h3000_0100, 1, 0, "R10 next-cycle visibility");
        cfg(7, 32'h3000_0000, 16, 0, 8'h00, 3, 0, 0);
        // R10: out-of-range index changes nothing
        cfg(13, 32'h4000_0000, 20, 1, 8'h00, 3, 0, 0);
        look(32'h4000_0010, 1, 1, "R10 ignored index 13");
        cfg(15, 32'h0800_0020, 5, 1, 8'h00, 3, 0, 0);
        look(32'h0800_0024, 1, 1, "R10 ignored index 15");

        // R2: guard window inside RAM wins
        look(32'h0800_0024, 1, 1, "R2 guard over RAM");
        look(32'h0800_0040, 2, 0, "R2 RAM past guard");
        look(32'h0800_1800, 2, 1, "R2 read-only window over RAM");
        // R3: clamped size code
        look(32'h2000_001C, 1, 0, "R3 inside clamped 32B window");
        look(32'h2000_0020, 1, 0, "R3 outside clamped 32B window");
        // R4: disabled subregions
        look(32'hFC90_0000, 1, 1, "R4 disabled part");
        look(32'hFE00_0000, 1, 1, "R4 enabled upper part");
        look(32'hFC7F_FFFC, 2, 0, "R4 enabled lower part");
        // R6: privileged-only window
        look(32'hFFF8_0100, 1, 0, "R6 unprivileged read of privileged window");
        look(32'hFFF8_0100, 2, 1, "R6 privileged write");
        look(32'hF000_0000, 2, 1, "R6 write to read-only");
        // R7: fetch rules
        look(32'hFE00_0000, 0, 1, "R7 fetch from device");
        look(32'h0000_1000, 0, 0, "R7 fetch from flash");
        look(32'h0840_0000, 0, 1, "R7 fetch from execute-never");
        // R9: stored type 3 and kind 3
        look(32'h5000_0004, 1, 1, "R9 type code 3");
        look(32'h0800_1000, 3, 0, "R9 kind 3 as read");

        // R2 sweep across every window's parts and edges
        for (int r = 0; r < NR; r++) begin
            for (int k = 0; k <= 9; k++) begin
                logic [31:0] a;
                logic [31:0] step;
                step = 32'd1 << (m_size[r] - 3);
                if (k == 9) a = m_base[r] - 32'd4;
                else        a = m_base[r] + 32'(k) * step + ((k % 2 == 1) ? 32'd4 : 32'd0);
                for (int kd = 0; kd < 3; kd++) begin
                    for (int p = 0; p < 2; p++) begin
                        look(a, kd, p[0], "R2 window sweep");
                    end
                end
            end
        end
        sweep_top("R5 R6 enabled top sweep");

        // R8 again with windows present
        mpu_on = 1'b0;
        look(32'h0800_0024, 1, 0, "R8 guard ignored when off");
        look(32'hFFF8_0000, 0, 0, "R8 fetch in system space when off");

        // R11: reset mid-run clears every window
        mpu_on = 1'b1;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        clear_model();
        look(32'h0000_1000, 1, 1, "R11 windows cleared by reset");
        look(32'hFFF8_0000, 2, 1, "R11 windows cleared by reset");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule